// File: doc/BRIEF.md
# Sign-Flip BPSK/QPSK Carrier Modulator

This block is a direct-digital phase modulator with no pulse shaping. A phase accumulator adds a tuning word on every clock. The top bits of the accumulator give a square-wave carrier. A serial bit stream arrives with a valid strobe. Each bit is placed in a pending register and moves to the active symbol only at a symbol boundary, so every symbol keeps a rectangular shape for its whole length. A programmable symbol period sets where the boundaries fall.

In the split modes, each leg bit flips the sign of its own carrier component. In BPSK only the in-phase leg is used. In QPSK the even-indexed bits drive the in-phase leg and the odd-indexed bits drive the quadrature leg, and the two signed components are added into one small signed sample. In the single-oscillator mode the two symbol bits do not flip signs. They select a phase offset of one, three, five or seven eighths of a turn, and that offset is added to the top of the oscillator phase. The output is the sign of the single shifted carrier.

Top module: `psk_signflip_mod`

## Requirements
- R1: While `rst_n` is low, the phase, the symbol counter and both active leg bits are zero. The output therefore reads +2 with `mode`=00 and 0 with `mode`=01, whatever the tuning word is.
- R2: The phase advances by `tune_word` on every clock, modulo 2^32. The in-phase carrier is +1 when the top two phase bits are 00 or 11 and -1 when they are 01 or 10. The quadrature carrier follows the same rule on the phase plus a quarter turn.
- R3: With `mode`=01, the first valid bit after reset and every second bit after it (the even-indexed bits) go to the in-phase leg. The odd-indexed bits go to the quadrature leg.
- R4: In the split modes a leg bit of 1 inverts its carrier component. With `mode`=01 the output is the sum of the two ±1 components, so it is -2, 0 or +2 as a 3-bit two's-complement value.
- R5: With `mode`=00 (BPSK), every valid bit replaces the pending in-phase bit, and the quadrature leg has no effect. The output is +2 or -2: the in-phase carrier with its sign flipped by the leg bit, then doubled.
- R6: With `mode[1]`=1 (single oscillator), the offset code {bI, bI^bQ, 1}, in eighths of a turn, is added to the top three phase bits. So 00→1/8, 01→3/8, 11→5/8 and 10→7/8, with bI being the even-indexed bit. The output is +2 or -2 by the in-phase carrier rule applied to the shifted phase. Mode codes 10 and 11 behave identically.
- R7: The pending bits are copied to the active legs on the P-th clock after reset and on every P-th clock after that, where P = `sym_period`. Between boundaries the legs hold, so bits that arrive mid-symbol do not reach the output before the next boundary.
- R8: A `sym_period` of 0 acts as 1, so the legs are updated on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | Marks `bit_in` as valid in this cycle |
| tune_word | input | 32 | Phase increment per clock (carrier frequency) |
| sym_period | input | 16 | Clocks per symbol; 0 is treated as 1 |
| mode | input | 2 | 00 BPSK, 01 QPSK split, 1x single-oscillator phase offset |
| sample_out | output | 3 | Signed carrier sample: -2, 0 or +2 |

## Verification
A wrong phase value shows at the output on the next clock, because the output is decoded from the phase without a register. With any tuning word that crosses a quadrant, the sign pattern of the carrier then departs from the model within a few cycles. A leg or pending bit that is stored wrongly, or a symbol boundary counted wrongly, appears as a sign error starting at the first boundary where the expected legs differ from the old ones. Updates that come too early are caught in the hold window before each boundary, and late updates are caught in the cycles just after it. A mode decode fault shows at once as a 0 in a mode that only allows ±2, or as a missing 0 in QPSK.

// File: rtl/psk_mod_pkg.sv
package psk_mod_pkg;

   // Modulation mode encoding; bit 1 selects the single-oscillator path
   typedef enum logic [1:0] {
      MODE_BPSK      = 2'b00,
      MODE_QPSK      = 2'b01,
      MODE_PHASE     = 2'b10,
      MODE_PHASE_ALT = 2'b11
   } mod_mode_e;

   localparam int SAMPLE_W = 3;

   localparam logic signed [SAMPLE_W-1:0] SAMPLE_POS  = 3'sd2;
   localparam logic signed [SAMPLE_W-1:0] SAMPLE_NEG  = -3'sd2;
   localparam logic signed [SAMPLE_W-1:0] SAMPLE_ZERO = 3'sd0;

   // A square-wave cosine is negative in the second and third quadrants
   function automatic logic quad_is_negative(input logic [1:0] quad);
      return quad[1] ^ quad[0];
   endfunction

endpackage

// File: rtl/psk_phase_accum.sv
module psk_phase_accum #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] tune,
   output logic [ACC_W-1:0] phase
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else begin
         phase <= phase + tune;
      end
   end

endmodule

// File: rtl/psk_sym_timer.sv
module psk_sym_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             tick
);

   logic [CNT_W-1:0] last_idx;

   // A period of zero behaves as one: every cycle is a boundary
   assign last_idx = (period == '0) ? '0 : period - 1'b1;
   // Greater-or-equal so that a period lowered on the fly still wraps
   assign tick     = (count >= last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (tick) begin
         count <= '0;
      end else begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/psk_bit_splitter.sv
module psk_bit_splitter (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_in,
   input  logic bit_valid,
   input  logic split_en,
   input  logic sym_tick,
   output logic leg_i,
   output logic leg_q
);

   logic pend_i;
   logic pend_q;
   logic odd_slot;

   // Collect incoming bits into pending registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_i   <= 1'b0;
         pend_q   <= 1'b0;
         odd_slot <= 1'b0;
      end else if (bit_valid) begin
         if (!split_en) begin
            pend_i <= bit_in;
         end else if (!odd_slot) begin
            pend_i   <= bit_in;
            odd_slot <= 1'b1;
         end else begin
            pend_q   <= bit_in;
            odd_slot <= 1'b0;
         end
      end
   end

   // Active legs change only at a symbol boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         leg_i <= 1'b0;
         leg_q <= 1'b0;
      end else if (sym_tick) begin
         leg_i <= pend_i;
         leg_q <= pend_q;
      end
   end

endmodule

// File: rtl/psk_carrier_combiner.sv
module psk_carrier_combiner
   import psk_mod_pkg::*;
#(
   parameter int ACC_W   = 32,
   parameter bit REG_OUT = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ACC_W-1:0]           phase,
   input  mod_mode_e                  mode,
   input  logic                       leg_i,
   input  logic                       leg_q,
   output logic signed [SAMPLE_W-1:0] sample
);

   logic [1:0] i_quad;
   logic [1:0] q_quad;
   logic [2:0] offset_code;
   logic [2:0] shifted_top;
   logic       i_neg;
   logic       q_neg;
   logic       o_neg;
   logic signed [SAMPLE_W-1:0] sample_d;

   assign i_quad      = phase[ACC_W-1 -: 2];
   // Quadrature carrier: the same square wave a quarter turn ahead
   assign q_quad      = i_quad + 2'd1;
   // Gray-ordered odd eighths of a turn
   assign offset_code = {leg_i, leg_i ^ leg_q, 1'b1};
   assign shifted_top = phase[ACC_W-1 -: 3] + offset_code;

   assign i_neg = quad_is_negative(i_quad) ^ leg_i;
   assign q_neg = quad_is_negative(q_quad) ^ leg_q;
   assign o_neg = quad_is_negative(shifted_top[2:1]);

   always_comb begin
      unique case (mode)
         MODE_BPSK: sample_d = i_neg ? SAMPLE_NEG : SAMPLE_POS;
         MODE_QPSK: begin
            if (i_neg && q_neg) begin
               sample_d = SAMPLE_NEG;
            end else if (!i_neg && !q_neg) begin
               sample_d = SAMPLE_POS;
            end else begin
               sample_d = SAMPLE_ZERO;
            end
         end
         default:   sample_d = o_neg ? SAMPLE_NEG : SAMPLE_POS;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sample <= SAMPLE_ZERO;
            end else begin
               sample <= sample_d;
            end
         end
      end else begin : g_comb_out
         assign sample = sample_d;
      end
   endgenerate

endmodule

// File: rtl/psk_signflip_mod.sv
module psk_signflip_mod
   import psk_mod_pkg::*;
#(
   parameter int ACC_W   = 32,
   parameter int CNT_W   = 16,
   parameter bit REG_OUT = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bit_in,
   input  logic                       bit_valid,
   input  logic [ACC_W-1:0]           tune_word,
   input  logic [CNT_W-1:0]           sym_period,
   input  logic [1:0]                 mode,
   output logic signed [SAMPLE_W-1:0] sample_out
);

   generate
      if (ACC_W < 3) begin : g_bad_acc_w
         $error("ACC_W must be at least 3 for the eighth-turn offsets");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("CNT_W must be at least 1");
      end
   endgenerate

   mod_mode_e        mode_e;
   logic [ACC_W-1:0] phase_acc;
   logic [CNT_W-1:0] sym_count;
   logic             sym_tick;
   logic             leg_i;
   logic             leg_q;

   assign mode_e = mod_mode_e'(mode);

   psk_phase_accum #(.ACC_W(ACC_W)) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .tune  (tune_word),
      .phase (phase_acc)
   );

   psk_sym_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .period (sym_period),
      .count  (sym_count),
      .tick   (sym_tick)
   );

   psk_bit_splitter u_split (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_in    (bit_in),
      .bit_valid (bit_valid),
      .split_en  (mode_e != MODE_BPSK),
      .sym_tick  (sym_tick),
      .leg_i     (leg_i),
      .leg_q     (leg_q)
   );

   psk_carrier_combiner #(.ACC_W(ACC_W), .REG_OUT(REG_OUT)) u_comb (
      .clk    (clk),
      .rst_n  (rst_n),
      .phase  (phase_acc),
      .mode   (mode_e),
      .leg_i  (leg_i),
      .leg_q  (leg_q),
      .sample (sample_out)
   );

endmodule

// File: rtl/psk_signflip_mod_chk.sv
module psk_signflip_mod_chk #(
   parameter int ACC_W   = 32,
   parameter int CNT_W   = 16,
   parameter bit REG_OUT = 1'b0
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [1:0]             mode,
   input logic [ACC_W-1:0]       tune,
   input logic [ACC_W-1:0]       acc,
   input logic [CNT_W-1:0]       cnt,
   input logic                   sym_tick,
   input logic                   leg_i,
   input logic                   leg_q,
   input logic signed [2:0]      sample_out
);

   // R4
   sample_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_out == 3'sd2) || (sample_out == -3'sd2) || (sample_out == 3'sd0));

   // R5
   single_leg_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!REG_OUT && mode != 2'b01) |-> (sample_out != 3'sd0));

   // R2
   phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (acc == $past(acc) + $past(tune)));

   // R7
   legs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_tick |=> ($stable(leg_i) && $stable(leg_q)));

   // R7
   boundary_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sym_tick |=> (cnt == '0));

endmodule

bind psk_signflip_mod psk_signflip_mod_chk #(
   .ACC_W   (ACC_W),
   .CNT_W   (CNT_W),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (mode),
   .tune       (tune_word),
   .acc        (phase_acc),
   .cnt        (sym_count),
   .sym_tick   (sym_tick),
   .leg_i      (leg_i),
   .leg_q      (leg_q),
   .sample_out (sample_out)
);

// File: tb/psk_signflip_mod_bench.sv
module psk_signflip_mod_bench;

   localparam int CLK_PERIOD = 10;
   localparam int ACC_W      = 32;
   localparam int CNT_W      = 16;
   localparam int NVEC       = 6;

   typedef struct packed {
      logic [1:0]  md;
      logic [15:0] per;
      logic [31:0] tw;
      logic        b0;
      logic        b1;
      logic        c0;
      logic        c1;
   } vec_t;

   // mode, period, tuning word, first pair, second pair
   localparam vec_t VECS [0:NVEC-1] = '{
      '{2'b01, 16'd8, 32'h1000_0000, 1'b1, 1'b0, 1'b0, 1'b1},
      '{2'b01, 16'd5, 32'h4000_0000, 1'b1, 1'b1, 1'b0, 1'b0},
      '{2'b00, 16'd6, 32'h2000_0000, 1'b0, 1'b1, 1'b1, 1'b0},
      '{2'b10, 16'd4, 32'h2000_0000, 1'b0, 1'b1, 1'b1, 1'b1},
      '{2'b11, 16'd7, 32'h0800_0000, 1'b1, 1'b0, 1'b0, 1'b0},
      '{2'b01, 16'd4, 32'hC000_0000, 1'b0, 1'b1, 1'b1, 1'b0}
   };

   logic              clk;
   logic              rst_n;
   logic              bit_in;
   logic              bit_valid;
   logic [ACC_W-1:0]  tune_word;
   logic [CNT_W-1:0]  sym_period;
   logic [1:0]        mode;
   logic signed [2:0] sample_out;

   int checks;
   int fails;

   psk_signflip_mod #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_psk_signflip_mod (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_in     (bit_in),
      .bit_valid  (bit_valid),
      .tune_word  (tune_word),
      .sym_period (sym_period),
      .mode       (mode),
      .sample_out (sample_out)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // Expected sample from the requirement text (R2, R4, R5, R6)
   function automatic logic signed [2:0] ref_sample(input logic [1:0] md, input logic [31:0] ph,
                                                    input logic li, input logic lq);
      logic [1:0] q;
      logic [1:0] qq;
      logic [2:0] p3;
      logic       cn;
      logic       qn;
      int         s;
      q  = ph[31:30];
      cn = (q == 2'b01) || (q == 2'b10);
      qq = q + 2'd1;
      qn = (qq == 2'b01) || (qq == 2'b10);
      if (md == 2'b00) begin
         return (cn ^ li) ? -3'sd2 : 3'sd2;
      end else if (md == 2'b01) begin
         s = ((cn ^ li) ? -1 : 1) + ((qn ^ lq) ? -1 : 1);
         return 3'(s);
      end
      p3 = ph[31:29] + {li, li ^ lq, 1'b1};
      return ((p3[2:1] == 2'b01) || (p3[2:1] == 2'b10)) ? -3'sd2 : 3'sd2;
   endfunction

   task automatic check(input string req, input logic signed [2:0] exp);
      checks++;
      if (sample_out !== exp) begin
         fails++;
         $display("FAIL %s: sample_out=%0d expected %0d", req, sample_out, exp);
      end
   endtask

   task automatic start_run();
      rst_n     = 1'b0;
      bit_valid = 1'b0;
      bit_in    = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      checks     = 0;
      fails      = 0;
      rst_n      = 1'b0;
      bit_in     = 1'b0;
      bit_valid  = 1'b0;
      tune_word  = 32'h1234_5678;
      sym_period = 16'd4;
      mode       = 2'b00;

      // R1: reset state, accumulator held while in reset
      repeat (3) @(negedge clk);
      check("R1 bpsk in reset", 3'sd2);
      mode = 2'b01;
      @(negedge clk);
      check("R1 qpsk in reset", 3'sd0);

      // Table walk: R2 R3 R4 R5 R6 R7
      for (int v = 0; v < NVEC; v++) begin
         int   p;
         logic li1, lq1, li2, lq2;
         mode       = VECS[v].md;
         sym_period = VECS[v].per;
         tune_word  = VECS[v].tw;
         p          = int'(VECS[v].per);
         li1 = (VECS[v].md == 2'b00) ? VECS[v].b1 : VECS[v].b0;
         lq1 = VECS[v].b1;
         li2 = (VECS[v].md == 2'b00) ? VECS[v].c1 : VECS[v].c0;
         lq2 = VECS[v].c1;
         start_run();
         for (int k = 0; k <= 2*p + 2; k++) begin
            logic [31:0] ph;
            logic        li, lq;
            string       tag;
            ph = tune_word * 32'(k);
            if (k < p) begin
               li = 1'b0; lq = 1'b0; tag = "R7 before first boundary";
            end else if (k < 2*p) begin
               li = li1; lq = lq1;
               tag = (k > p + 2) ? "R7 hold mid-symbol" :
                     (mode == 2'b00) ? "R5 bpsk" : (mode == 2'b01) ? "R3 R4 qpsk split" : "R6 phase offset";
            end else begin
               li = li2; lq = lq2;
               tag = (mode == 2'b00) ? "R5 bpsk second" : (mode == 2'b01) ? "R2 R4 qpsk second" : "R6 phase second";
            end
            check(tag, ref_sample(mode, ph, li, lq));
            bit_valid = 1'b0;
            if (k + 1 == 1)     begin bit_valid = 1'b1; bit_in = VECS[v].b0; end
            if (k + 1 == 2)     begin bit_valid = 1'b1; bit_in = VECS[v].b1; end
            if (k + 1 == p + 1) begin bit_valid = 1'b1; bit_in = VECS[v].c0; end
            if (k + 1 == p + 2) begin bit_valid = 1'b1; bit_in = VECS[v].c1; end
            @(posedge clk);
            @(negedge clk);
         end
      end

      // R8: period 0 latches on every clock
      mode       = 2'b00;
      tune_word  = 32'h0;
      sym_period = 16'd0;
      start_run();
      bit_valid = 1'b1; bit_in = 1'b1;
      @(posedge clk); @(negedge clk);
      bit_valid = 1'b0;
      check("R8 leg not yet updated", 3'sd2);
      @(posedge clk); @(negedge clk);
      check("R8 leg updated next clock", -3'sd2);
      bit_valid = 1'b1; bit_in = 1'b0;
      @(posedge clk); @(negedge clk);
      bit_valid = 1'b0;
      check("R8 hold one clock", -3'sd2);
      @(posedge clk); @(negedge clk);
      check("R8 second update", 3'sd2);

      // R6: mode 11 equals mode 10 at zero phase, symbol 11 -> 5/8 turn -> negative
      mode       = 2'b11;
      sym_period = 16'd1;
      start_run();
      bit_valid = 1'b1; bit_in = 1'b1;
      @(posedge clk); @(negedge clk);
      bit_in = 1'b1;
      @(posedge clk); @(negedge clk);
      bit_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R6 mode 11 offset 5/8", -3'sd2);
      mode = 2'b10;
      @(negedge clk);
      check("R6 mode 10 offset 5/8", -3'sd2);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule